// File: doc/BRIEF.md
# Masked Associative Memory Search

This block is a small content-addressable store of `WORDS` entries, each `WIDTH` bits wide. Each entry has its own active flag. A write port sets an entry's data and its active flag together, and reset marks every entry inactive.

A search is started with a one-cycle pulse on `start`. It compares the `arg` input against every active entry, but only in the bit positions where `key` holds a one. The block latches two vectors:

- a per-entry match vector;
- a per-entry vector that is set when the key-masked argument is strictly greater than the key-masked stored value.

The latched matches are then drained in ascending entry order, one per cycle, each with a valid strobe. A done pulse marks the end of the drain.

A typical use is a lookup against a small table of tags or patterns with don't-care columns. The read-out stream gives each hit's entry index and its contents, so several hits can be handled in turn.

Top module: `cam_search`

## Requirements
- R1: An entry matches a search when its active flag is 1 and, in every bit position where `key` is 1, `arg` and the stored bit are equal. Bit positions where `key` is 0 are ignored.
- R2: A search with `key` equal to all zeros sets no bit of `match_vec` and no bit of `gt_vec`.
- R3: An entry whose active flag is 0 sets neither its `match_vec` bit nor its `gt_vec` bit. Reset clears every active flag. A write stores `wr_data` and `wr_active` together, and searches started on a later cycle see the new values.
- R4: Bit i of `gt_vec` is 1 when entry i is active and `(arg & key)` is strictly greater than `(entry_i & key)` as unsigned numbers. When the two are equal, the bit is 0.
- R5: `start` is sampled on a rising clock edge. At that edge `match_vec` and `gt_vec` take the search result, and they hold it until the next start.
- R6: After the edge that samples `start`, the latched matches come out on the following cycles, one per cycle, in ascending index order. On each of these cycles `rd_valid` is 1, `rd_idx` is the entry index, and `rd_data` is that entry's contents at that cycle. On the start edge itself `rd_valid` is 0.
- R7: `rd_done` is a one-cycle pulse on the cycle after the last matched entry is presented. With no matches, it comes on the cycle after the start edge. `rd_done` and `rd_valid` are never 1 together.
- R8: Writes made while a drain is running change neither the latched `match_vec` nor the sequence of indices being drained.
- R9: A `start` sampled during a drain abandons that drain. The new search is latched and drained from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | IDX_W | Entry written |
| wr_data | input | WIDTH | Value written |
| wr_active | input | 1 | Active flag written with the value |
| arg | input | WIDTH | Search argument |
| key | input | WIDTH | Compare enable per bit position |
| start | input | 1 | Search start pulse |
| match_vec | output | WORDS | Latched per-entry match |
| gt_vec | output | WORDS | Latched per-entry strictly-greater flag |
| rd_valid | output | 1 | Drain output valid |
| rd_idx | output | IDX_W | Index of the drained entry |
| rd_data | output | WIDTH | Contents of the drained entry |
| rd_done | output | 1 | Drain finished pulse |

## Verification
The bench builds the block with four entries of four bits. With that size, every combination of argument and key, 256 searches per table, can be applied against several table contents. The tables include duplicate values, inactive entries and the empty table after reset. At this size every drain length from zero to four hits occurs, and every ordering of key-enabled differing bits for the greater-than scan is exercised. Directed sequences cover writes issued during a drain and a restart in the middle of a drain.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_SCAN = 1'b1
    } drain_e;

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_addr,
    input  logic [WIDTH-1:0]              wr_data,
    input  logic                          wr_active,
    output logic [WORDS-1:0][WIDTH-1:0]   ent_data,
    output logic [WORDS-1:0]              ent_act
);

    typedef struct packed {
        logic [WORDS-1:0][WIDTH-1:0] data;
        logic [WORDS-1:0]            act;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && (int'(wr_addr) < WORDS)) begin
            s_d.data[wr_addr] = wr_data;
            s_d.act[wr_addr]  = wr_active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ent_data = s_q.data;
    assign ent_act  = s_q.act;

endmodule

// File: rtl/cam_word_cmp.sv
module cam_word_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] word,
    input  logic             act,
    output logic             hit,
    output logic             gt
);

    logic [WIDTH-1:0] diff;
    logic             decided;
    logic             above;

    always_comb begin
        // Differing bits that the key enables.
        diff    = (arg ^ word) & key;
        hit     = act && (|key) && !(|diff);
        decided = 1'b0;
        above   = 1'b0;
        // Scan from the top; the highest enabled differing bit decides.
        for (int j = WIDTH - 1; j >= 0; j--) begin
            if (!decided && diff[j]) begin
                decided = 1'b1;
                above   = arg[j];
            end
        end
        gt = act && above;
    end

endmodule

// File: rtl/cam_drain.sv
module cam_drain
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [WORDS-1:0]              hit_in,
    input  logic [WORDS-1:0]              gt_in,
    input  logic [WORDS-1:0][WIDTH-1:0]   ent_data,
    output logic [WORDS-1:0]              hits,
    output logic [WORDS-1:0]              gts,
    output logic                          rd_valid,
    output logic [IDX_W-1:0]              rd_idx,
    output logic [WIDTH-1:0]              rd_data,
    output logic                          rd_done
);

    typedef struct packed {
        drain_e           st;
        logic [WORDS-1:0] pend;
        logic [WORDS-1:0] hits;
        logic [WORDS-1:0] gts;
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] data;
        logic             done;
    } drain_t;

    drain_t r_d, r_q;
    logic [IDX_W-1:0] pick;

    // Lowest pending index wins.
    always_comb begin
        pick = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (r_q.pend[i]) begin
                pick = IDX_W'(i);
            end
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.done  = 1'b0;
        if (start) begin
            r_d.hits = hit_in;
            r_d.gts  = gt_in;
            r_d.pend = hit_in;
            r_d.st   = DR_SCAN;
        end else if (r_q.st == DR_SCAN) begin
            if (|r_q.pend) begin
                r_d.valid      = 1'b1;
                r_d.idx        = pick;
                r_d.data       = ent_data[pick];
                r_d.pend[pick] = 1'b0;
            end else begin
                r_d.done = 1'b1;
                r_d.st   = DR_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hits     = r_q.hits;
    assign gts      = r_q.gts;
    assign rd_valid = r_q.valid;
    assign rd_idx   = r_q.idx;
    assign rd_data  = r_q.data;
    assign rd_done  = r_q.done;

endmodule

// File: rtl/cam_search.sv
module cam_search #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_active,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    input  logic             start,
    output logic [WORDS-1:0] match_vec,
    output logic [WORDS-1:0] gt_vec,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_done
);

    logic [WORDS-1:0][WIDTH-1:0] ent_data;
    logic [WORDS-1:0]            ent_act;
    logic [WORDS-1:0]            hit_now;
    logic [WORDS-1:0]            gt_now;

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_active (wr_active),
        .ent_data  (ent_data),
        .ent_act   (ent_act)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_cmp
        cam_word_cmp #(.WIDTH(WIDTH)) u_cmp (
            .arg  (arg),
            .key  (key),
            .word (ent_data[g]),
            .act  (ent_act[g]),
            .hit  (hit_now[g]),
            .gt   (gt_now[g])
        );
    end

    cam_drain #(.WORDS(WORDS), .WIDTH(WIDTH)) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .hit_in   (hit_now),
        .gt_in    (gt_now),
        .ent_data (ent_data),
        .hits     (match_vec),
        .gts      (gt_vec),
        .rd_valid (rd_valid),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_done  (rd_done)
    );

endmodule

// File: rtl/cam_search_chk.sv
module cam_search_chk #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] key,
    input logic             start,
    input logic [WORDS-1:0] match_vec,
    input logic [WORDS-1:0] gt_vec,
    input logic             rd_valid,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_done
);

    // R4: equal on enabled bits and strictly greater cannot both hold.
    p_match_gt_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & gt_vec) == '0);

    // R2: an all-zero key latches empty vectors.
    p_zero_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && ($past(key) == '0)) |-> (match_vec == '0 && gt_vec == '0));

    // R5: the latched vector only changes on a start.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start) |-> $stable(match_vec));

    // R6: every drained index is a latched match.
    p_rd_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> match_vec[rd_idx]);

    // R6: back-to-back outputs climb in index.
    p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_idx > $past(rd_idx)));

    // R7: done is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R7: done never coincides with an output.
    p_done_valid_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_done));

endmodule

bind cam_search cam_search_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key       (key),
    .start     (start),
    .match_vec (match_vec),
    .gt_vec    (gt_vec),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_done   (rd_done)
);

// File: tb/cam_search_bench.sv
module cam_search_bench;

    localparam int NW = 4;
    localparam int BW = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic          wr_active = 1'b0;
    logic [BW-1:0] arg = '0;
    logic [BW-1:0] key = '0;
    logic          start = 1'b0;
    logic [NW-1:0] match_vec;
    logic [NW-1:0] gt_vec;
    logic          rd_valid;
    logic [AW-1:0] rd_idx;
    logic [BW-1:0] rd_data;
    logic          rd_done;

    int checks = 0;
    int fails  = 0;

    logic [BW-1:0] m_data [NW];
    logic          m_act  [NW];

    always #4 clk = ~clk;

    cam_search #(.WORDS(NW), .WIDTH(BW)) u_cam_search (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_active(wr_active), .arg(arg), .key(key),
        .start(start), .match_vec(match_vec), .gt_vec(gt_vec),
        .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input bit act);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = BW'(d); wr_active = act;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[a] = BW'(d);
        m_act[a]  = act;
    endtask

    function automatic logic [NW-1:0] exp_hit(input logic [BW-1:0] a, input logic [BW-1:0] k);
        logic [NW-1:0] v;
        for (int i = 0; i < NW; i++)
            v[i] = m_act[i] && (k != '0) && (((a ^ m_data[i]) & k) == '0);
        return v;
    endfunction

    function automatic logic [NW-1:0] exp_gt(input logic [BW-1:0] a, input logic [BW-1:0] k);
        logic [NW-1:0] v;
        for (int i = 0; i < NW; i++)
            v[i] = m_act[i] && ((a & k) > (m_data[i] & k));
        return v;
    endfunction

    task automatic do_search(input logic [BW-1:0] a, input logic [BW-1:0] k);
        logic [NW-1:0] em;
        logic [NW-1:0] eg;
        em = exp_hit(a, k);
        eg = exp_gt(a, k);
        @(negedge clk);
        arg = a; key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (k == '0)
            chk(match_vec == '0 && gt_vec == '0, "R2 zero key", int'({match_vec, gt_vec}), 0);
        chk(match_vec == em, "R1/R3/R5 match_vec", int'(match_vec), int'(em));
        chk(gt_vec == eg, "R4 gt_vec", int'(gt_vec), int'(eg));
        chk(!rd_valid, "R6 no output on start edge", int'(rd_valid), 0);
        for (int i = 0; i < NW; i++) begin
            if (em[i]) begin
                @(negedge clk);
                chk(rd_valid && rd_idx == AW'(i) && rd_data == m_data[i] && !rd_done,
                    "R6 readout", int'({rd_valid, rd_idx, rd_data}), int'({1'b1, AW'(i), m_data[i]}));
            end
        end
        @(negedge clk);
        chk(rd_done && !rd_valid, "R7 done pulse", int'({rd_done, rd_valid}), 2);
    endtask

    task automatic sweep();
        for (int a = 0; a < 16; a++)
            for (int k = 0; k < 16; k++)
                do_search(BW'(a), BW'(k));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_data[i] = '0;
            m_act[i]  = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(match_vec == '0 && gt_vec == '0, "R5 reset vectors", int'({match_vec, gt_vec}), 0);
        chk(!rd_valid && !rd_done, "R7 reset strobes", int'({rd_valid, rd_done}), 0);

        // R3: after reset no entry is active.
        sweep();

        // Distinct values, all active.
        wr(0, 3, 1); wr(1, 5, 1); wr(2, 3, 1); wr(3, 12, 1);
        sweep();

        // Duplicates and inactive entries (R3).
        wr(0, 9, 1); wr(1, 9, 0); wr(2, 0, 1); wr(3, 15, 1);
        sweep();

        // All equal, all active: four-hit drains.
        wr(0, 6, 1); wr(1, 6, 1); wr(2, 6, 1); wr(3, 6, 1);
        sweep();

        // R5: result held while inputs move.
        do_search(4'h6, 4'hF);
        arg = 4'h0; key = 4'h1;
        repeat (3) @(negedge clk);
        chk(match_vec == 4'hF && gt_vec == 4'h0, "R5 hold", int'({match_vec, gt_vec}), 8'hF0);

        // R8: write during drain leaves the sequence intact.
        @(negedge clk);
        arg = 4'h6; key = 4'hF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd0, "R8 first out", int'(rd_idx), 0);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 4'h6; wr_active = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; m_act[3] = 1'b0;
        chk(rd_valid && rd_idx == 2'd1, "R8 second out", int'(rd_idx), 1);
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd2, "R8 third out", int'(rd_idx), 2);
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd3 && match_vec == 4'hF, "R8 fourth out",
            int'({match_vec, 2'b00, rd_idx}), 8'hF3);
        @(negedge clk);
        chk(rd_done, "R8 done", int'(rd_done), 1);
        do_search(4'h6, 4'hF);

        // R9: restart in mid drain.
        wr(3, 6, 1);
        @(negedge clk);
        arg = 4'h6; key = 4'hF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd1, "R9 before restart", int'(rd_idx), 1);
        arg = 4'h6; key = 4'h3; start = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 4'h1; wr_active = 1'b1;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        chk(!rd_valid && match_vec == 4'hF, "R9 restart latched", int'({rd_valid, match_vec}), 8'h0F);
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd0, "R9 restart from lowest", int'(rd_idx), 0);
        m_data[2] = 4'h1;
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd1, "R9 second", int'(rd_idx), 1);
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd2 && rd_data == 4'h1, "R6/R9 current data",
            int'(rd_data), 1);
        @(negedge clk);
        chk(rd_valid && rd_idx == 2'd3, "R9 fourth", int'(rd_idx), 3);
        @(negedge clk);
        chk(rd_done, "R9 done", int'(rd_done), 1);

        // R3: the write of entry 2 is seen by the next search.
        do_search(4'h1, 4'hF);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule